// File: doc/BRIEF.md
# Reload-Latching Watchdog Timer

This block guards a system against stalled software. A single timeout value arrives on a plain register write port. The first nonzero value written arms the timer and is kept as the reload value. From then on the counter steps down by one every clock cycle. Software must write again before the count runs out. Any later write restarts the count from the kept value, whatever data it carries. If the count reaches zero, the block raises a reset request pulse for the system's reset network. It also sets a sticky status flag, so that software running after the restart can tell a watchdog restart from a power-on reset.

The flag sits outside the reach of the system reset that the watchdog itself causes. Only the asynchronous power-on reset clears it, or a write of zero while the timer is disarmed. A zero write while disarmed does not arm the timer. The system reset input (`sys_rst`) disarms the timer and forgets the kept value, so the next nonzero write becomes a new first write. The write port has no back-pressure: `wr_en` is a one-cycle strobe that the block always accepts.

Top module: `wdog_timer`

## Requirements
- R1: After `rst_n` is released, `rst_req` and `wd_flag` are 0. Without a nonzero write the timer stays disarmed and never raises `rst_req`.
- R2: A write of nonzero value N while disarmed arms the timer. If no further write or `sys_rst` arrives, `rst_req` is first seen high after the Nth rising edge that follows the write edge.
- R3: A write while armed restarts the count from the first-written value, and its data is ignored. The request then comes N edges after that write.
- R4: A write of zero while disarmed clears `wd_flag` and leaves the timer disarmed.
- R5: Suppose a write arrives in the same cycle that would otherwise end the count. The write wins: the count is reloaded and no request is raised in that cycle.
- R6: Each expiry holds `rst_req` high for exactly PULSE_LEN consecutive cycles.
- R7: Expiry sets `wd_flag`. The flag keeps its value through `sys_rst`. Only `rst_n` low or a zero write while disarmed clears it.
- R8: `sys_rst` high at an edge disarms the timer and drops the kept value. A write in that same cycle has no effect. After `sys_rst`, the next nonzero write latches its own value.
- R9: Expiry disarms the timer. The next nonzero write latches a new timeout value.
- R10: A write of zero while armed acts as a reload: it does not clear `wd_flag` and does not disarm the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count step per rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low; clears everything including the flag |
| sys_rst | input | 1 | Synchronous system reset; disarms the timer and keeps the flag |
| wr_en | input | 1 | Write strobe for the timeout register |
| wr_data | input | CNT_W | Timeout value in clock cycles (used only on the first write) |
| rst_req | output | 1 | Reset request pulse, PULSE_LEN cycles long |
| wd_flag | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
Directed cases check the following:
- A single arming write with no service, which measures the exact expiry cycle.
- Service writes carrying a different value, which shows whether the data is ignored.
- A service write that lands on the final count step, which separates write priority from expiry.
- Zero writes in the armed and disarmed states, which show the flag clearing apart from a reload.

Further cases apply `sys_rst` and let the timer expire, then write again. These tell whether a fresh value is latched afterwards or a stale one is kept. A long random phase mixes sparse writes, zero data and rare `sys_rst`. It compares both outputs every cycle with a cycle model built from the requirements, which covers the interleavings that the directed cases miss.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WD_CNT_W_DEF  = 16;
  localparam int WD_PULSE_DEF  = 4;

  function automatic int wd_pulse_w(input int len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction
endpackage

// File: rtl/wdog_reload_latch.sv
module wdog_reload_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             expire,
  output logic             armed,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             clr_flag
);
  logic [CNT_W-1:0] reload_q;
  logic             data_nz;
  logic             first_wr;

  assign data_nz  = |wr_data;
  assign first_wr = wr_en && !sys_rst && !armed && data_nz;
  assign load     = wr_en && !sys_rst && (armed || data_nz);
  assign load_val = armed ? reload_q : wr_data;
  assign clr_flag = wr_en && !sys_rst && !armed && !data_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      reload_q <= '0;
    end else if (sys_rst || expire) begin
      armed    <= 1'b0;
      reload_q <= '0;
    end else if (first_wr) begin
      armed    <= 1'b1;
      reload_q <= wr_data;
    end
  end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             armed,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  assign expire = armed && (cnt_q == ONE) && !load && !sys_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (sys_rst)               cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (expire)                cnt_q <= '0;
    else if (armed && cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_flag,
  output logic rst_req,
  output logic wd_flag
);
  localparam int PW = wdog_pkg::wd_pulse_w(PULSE_LEN);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);
  logic [PW-1:0] pcnt_q;

  assign rst_req = (pcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt_q <= '0;
    else if (expire)         pcnt_q <= PLEN;
    else if (pcnt_q != '0)   pcnt_q <= pcnt_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wd_flag <= 1'b0;
    else if (expire)    wd_flag <= 1'b1;
    else if (clr_flag)  wd_flag <= 1'b0;
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W     = wdog_pkg::WD_CNT_W_DEF,
  parameter int PULSE_LEN = wdog_pkg::WD_PULSE_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic             rst_req,
  output logic             wd_flag
);
  logic             armed_w;
  logic             load_w;
  logic [CNT_W-1:0] load_val_w;
  logic             clr_flag_w;
  logic             expire_w;

  wdog_reload_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .wr_en(wr_en), .wr_data(wr_data), .expire(expire_w),
    .armed(armed_w), .load(load_w), .load_val(load_val_w),
    .clr_flag(clr_flag_w)
  );

  wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .armed(armed_w), .load(load_w), .load_val(load_val_w),
    .expire(expire_w)
  );

  wdog_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .expire(expire_w),
    .clr_flag(clr_flag_w), .rst_req(rst_req), .wd_flag(wd_flag)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W     = 16,
  parameter int PULSE_LEN = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             rst_req,
  input logic             wd_flag,
  input logic             armed
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hi_run <= '0;
    else if (!rst_req)               hi_run <= '0;
    else if (hi_run != 16'hFFFF)     hi_run <= hi_run + 16'd1;
  end

  p_req_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(armed));

  p_write_blocks_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sys_rst && armed) |=> !$rose(rst_req));

  p_flag_with_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> wd_flag);

  p_flag_clear_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_flag) |-> $past(wr_en && !sys_rst && !armed && (wr_data == '0)));

  p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !armed);

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (32'(hi_run) >= PULSE_LEN));

  p_disarm_on_expiry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> !armed);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wr_en(wr_en),
  .wr_data(wr_data), .rst_req(rst_req), .wd_flag(wd_flag), .armed(armed_w)
);

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PLEN       = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sys_rst = 1'b0;
  logic             wr_en = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             rst_req;
  logic             wd_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // cycle model built from the requirements
  bit             m_armed;
  bit [CNT_W-1:0] m_reload, m_cnt;
  int             m_pcnt;
  bit             m_flag;

  wdog_timer #(.CNT_W(CNT_W), .PULSE_LEN(PLEN)) dut (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wr_en(wr_en),
    .wr_data(wr_data), .rst_req(rst_req), .wd_flag(wd_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_req();
    return m_pcnt != 0;
  endfunction

  task automatic model_reset();
    m_armed = 0; m_reload = '0; m_cnt = '0; m_pcnt = 0; m_flag = 0;
  endtask

  task automatic model_edge(input bit we, input bit [CNT_W-1:0] d, input bit sr);
    bit ld, ex, clr;
    bit [CNT_W-1:0] lv;
    ld  = we && !sr && (m_armed || d != 0);
    lv  = m_armed ? m_reload : d;
    ex  = m_armed && m_cnt == 1 && !ld && !sr;
    clr = we && !sr && !m_armed && d == 0;
    m_pcnt = ex ? PLEN : (m_pcnt != 0 ? m_pcnt - 1 : 0);
    if (ex) m_flag = 1; else if (clr) m_flag = 0;
    if (sr) m_cnt = '0; else if (ld) m_cnt = lv; else if (ex) m_cnt = '0;
    else if (m_armed && m_cnt != 0) m_cnt = m_cnt - 1;
    if (sr || ex) begin m_armed = 0; m_reload = '0; end
    else if (we && !m_armed && d != 0) begin m_armed = 1; m_reload = d; end
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: apply inputs, advance model, sample after the edge
  task automatic step(input bit we, input bit [CNT_W-1:0] d, input bit sr);
    wr_en = we; wr_data = d; sys_rst = sr;
    model_edge(we, d, sr);
    @(posedge clk); #1;
    wr_en = 0; wr_data = '0; sys_rst = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0);
  endtask

  // after a write edge, expect the request after exactly n more edges
  task automatic expect_expiry(input string tag, input int n);
    for (int i = 1; i < n; i++) begin
      step(0, '0, 0);
      check(tag, rst_req, 1'b0);
    end
    step(0, '0, 0);
    check(tag, rst_req, 1'b1);
  endtask

  task automatic do_por();
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); rst_n = 1; #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired, run hung");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit [31:0] seed;
    model_reset();
    seed = $urandom(32'h5A17);
    do_por();
    check("R1 req after reset", rst_req, 1'b0);
    check("R1 flag after reset", wd_flag, 1'b0);
    for (int i = 0; i < 40; i++) begin
      step(0, '0, 0);
      check("R1 no request while disarmed", rst_req, 1'b0);
    end

    // R2: arm with 5, exact expiry
    step(1, 16'd5, 0);
    expect_expiry("R2 expiry after N edges", 5);
    check("R7 flag set on expiry", wd_flag, 1'b1);
    // R6: pulse length (first high cycle already seen)
    for (int i = 1; i < PLEN; i++) begin
      step(0, '0, 0);
      check("R6 pulse held", rst_req, 1'b1);
    end
    step(0, '0, 0);
    check("R6 pulse ends", rst_req, 1'b0);

    // R7: flag survives sys_rst
    step(0, '0, 1);
    check("R7 flag kept through sys_rst", wd_flag, 1'b1);

    // R10: zero write while armed reloads and keeps flag
    step(1, 16'd6, 0);
    idle(3);
    step(1, 16'd0, 0);
    check("R10 flag kept on zero write while armed", wd_flag, 1'b1);
    expect_expiry("R10 zero write reloads", 6);
    idle(PLEN + 2);

    // R4: zero write while disarmed clears flag, no arming
    step(1, 16'd0, 0);
    check("R4 flag cleared", wd_flag, 1'b0);
    for (int i = 0; i < 30; i++) begin
      step(0, '0, 0);
      check("R4 zero write does not arm", rst_req, 1'b0);
    end

    // R3: later write reloads first value, data ignored
    step(1, 16'd8, 0);
    idle(3);
    step(1, 16'd100, 0);
    expect_expiry("R3 reload uses first value", 8);
    idle(PLEN + 2);

    // R5: write on the final count step wins
    step(1, 16'd3, 0);
    idle(2);
    step(1, 16'd9, 0);
    check("R5 no request when write meets expiry", rst_req, 1'b0);
    expect_expiry("R5 count restarted from 3", 3);
    idle(PLEN + 2);

    // R8: sys_rst disarms, next write latches its own value
    step(1, 16'd10, 0);
    idle(2);
    step(1, 16'd10, 1);
    for (int i = 0; i < 20; i++) begin
      step(0, '0, 0);
      check("R8 disarmed by sys_rst", rst_req, 1'b0);
    end
    step(1, 16'd4, 0);
    expect_expiry("R8 new value after sys_rst", 4);
    idle(PLEN + 2);

    // R9: after expiry, a new value is latched
    step(1, 16'd2, 0);
    expect_expiry("R9 new value after expiry", 2);
    idle(PLEN + 2);

    // R7: power-on reset clears flag
    check("R7 flag set before por", wd_flag, 1'b1);
    do_por();
    check("R7 flag cleared by rst_n", wd_flag, 1'b0);

    // random phase against the cycle model
    for (int i = 0; i < 6000; i++) begin
      bit we, sr;
      bit [CNT_W-1:0] d;
      we = ($urandom_range(0, 7) == 0);
      sr = ($urandom_range(0, 199) == 0);
      d  = ($urandom_range(0, 5) == 0) ? '0 : CNT_W'($urandom_range(1, 24));
      step(we, d, sr);
      check("R3 random req vs model", rst_req, model_req());
      check("R7 random flag vs model", wd_flag, m_flag);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule